// File: doc/BRIEF.md
# Region-Gated Cache-Line CRC32C Checker

This block sits on the fill path between a last-level cache and a memory device. The cache issues a fill request for a line address. The block fetches the line from memory and collects it as 32-bit words. When the line lies inside a protected window that software has set up, the block also reads the 32-bit checksum kept for that line in a separate checksum store. It compares that stored value with a CRC32C it computes over the returned data. Only then does it hand the line back to the cache. If the two values differ, the line is returned with an error flag and a one-cycle interrupt pulse goes to software.

Lines outside the window are fetched and returned with no checksum lookup. Only one fill is handled at a time. Every data path uses valid/ready handshakes. A transfer happens on a rising edge where both valid and ready are high. A source that has raised valid keeps valid and its payload unchanged until that edge. The window bounds and the interrupt are plain level signals.

Top module: `line_crc_verifier`

## Requirements
- R1: A fill is checked when its byte address A satisfies lo <= A < hi, where lo and hi come from `win_lo` and `win_hi`. The lower bound is inclusive and the upper bound is exclusive, so a window with lo == hi protects nothing.
- R2: A fill outside the window is returned with `fill_err` = 0. It raises no `sum_req_valid` and no `err_irq`.
- R3: The checksum is CRC32C in reflected form, using polynomial 0x82F63B78, an initial value of 0xFFFFFFFF and a final XOR of 0xFFFFFFFF. Word 0 of the line goes in first. Within each word, byte bits [7:0] go in first, so 32 zero bytes give 0x8A9136AA.
- R4: A checked fill issues exactly one checksum-store read, at the line index, which is the byte address shifted right by log2 of the line size in bytes.
- R5: On a checked fill, a stored value that differs from the computed CRC gives `fill_err` = 1 and a single-cycle `err_irq` pulse. A matching value gives `fill_err` = 0 and no pulse.
- R6: Once `fill_valid` is high it stays high, with `fill_data` and `fill_err` unchanged, until `fill_ready` is taken. `fill_data` holds word k in bits [32k+31:32k].
- R7: `req_ready` is high when idle. It drops on the cycle after a request is accepted and stays low until the fill handshake completes, so at most one fill is outstanding.
- R8: Each fill issues exactly one memory read, at the line-aligned address, and takes the line's words in order. Gaps in `mem_rsp_valid` are honoured.
- R9: After reset, `req_ready` is 1, and `fill_valid`, `mem_req_valid`, `sum_req_valid` and `err_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_lo | input | AW | Window start byte address (inclusive) |
| win_hi | input | AW | Window end byte address (exclusive) |
| req_valid | input | 1 | Fill request valid |
| req_ready | output | 1 | Block can take a fill request |
| req_addr | input | AW | Fill byte address |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Line-aligned memory read address |
| mem_rsp_valid | input | 1 | Memory data word valid |
| mem_rsp_ready | output | 1 | Block accepts a data word |
| mem_rsp_data | input | 32 | Memory data word |
| sum_req_valid | output | 1 | Checksum-store read valid |
| sum_req_ready | input | 1 | Checksum store accepts the read |
| sum_req_addr | output | AW-log2(line bytes) | Line index to look up |
| sum_rsp_valid | input | 1 | Stored checksum valid |
| sum_rsp_ready | output | 1 | Block accepts the stored checksum |
| sum_rsp_data | input | 32 | Stored checksum |
| fill_valid | output | 1 | Returned line valid |
| fill_ready | input | 1 | Cache accepts the line |
| fill_data | output | 32*LINE_WORDS | Returned line, word 0 in the low bits |
| fill_err | output | 1 | Checksum mismatch on this line |
| err_irq | output | 1 | One-cycle interrupt on mismatch |

## Verification
The bench runs with 32-byte lines and sweeps every line address of a small address space. This lands fills exactly on the lower bound, on the last line below the upper bound and on the upper bound itself. A window test that is off by one would check one line too many or too few; the bench sees this as a stray or missing checksum read. Published CRC32C vectors for all-zero, all-ones and incrementing bytes catch a wrong byte order, seed or final inversion, which would turn good lines into false errors. Memory-word gaps and held-off fill acceptance test the handshake rules. A block that skipped a stall would return shifted words, and one that dropped the fill early would lose the line or repeat the interrupt.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
  localparam logic [31:0] CRC_POLY = 32'h82F63B78;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MREQ, ST_DATA, ST_SREQ, ST_SRSP, ST_OUT
  } vstate_e;

  // One 32-bit word folded bit by bit, LSB first (byte [7:0] leads).
  function automatic logic [31:0] crc_step_word(input logic [31:0] crc_in,
                                                input logic [31:0] w);
    logic [31:0] c;
    c = crc_in;
    for (int i = 0; i < 32; i++) begin
      c = (c >> 1) ^ (((c[0] ^ w[i]) == 1'b1) ? CRC_POLY : 32'h0);
    end
    return c;
  endfunction
endpackage

// File: rtl/lcv_region_match.sv
module lcv_region_match #(
  parameter int AW = 40
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);
  // Inclusive lower bound, exclusive upper bound.
  always_comb hit = (addr >= lo) && (addr < hi);
endmodule

// File: rtl/lcv_crc_accum.sv
module lcv_crc_accum
  import lcv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        en,
  input  logic [31:0] word,
  output logic [31:0] crc_out
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (start) crc_q <= CRC_SEED;
    else if (en)    crc_q <= crc_step_word(crc_q, word);
  end

  always_comb crc_out = ~crc_q;

  a_r3_seed_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (crc_out == ~CRC_SEED));
endmodule

// File: rtl/lcv_line_buffer.sv
module lcv_line_buffer #(
  parameter int LINE_WORDS = 16,
  localparam int IDXW = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IDXW-1:0]         wr_idx,
  input  logic [31:0]             wr_word,
  output logic [LINE_WORDS*32-1:0] line_out
);
  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDXW'(g))) word_q <= wr_word;
    end
    assign line_out[32*g +: 32] = word_q;
  end
endmodule

// File: rtl/line_crc_verifier.sv
module line_crc_verifier
  import lcv_pkg::*;
#(
  parameter int AW         = 40,
  parameter int LINE_WORDS = 16,
  localparam int LINE_BYTES = LINE_WORDS * 4,
  localparam int OFFW       = $clog2(LINE_BYTES),
  localparam int LW         = AW - OFFW,
  localparam int IDXW       = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int LINEW      = LINE_WORDS * 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    win_lo,
  input  logic [AW-1:0]    win_hi,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [31:0]      mem_rsp_data,
  output logic             sum_req_valid,
  input  logic             sum_req_ready,
  output logic [LW-1:0]    sum_req_addr,
  input  logic             sum_rsp_valid,
  output logic             sum_rsp_ready,
  input  logic [31:0]      sum_rsp_data,
  output logic             fill_valid,
  input  logic             fill_ready,
  output logic [LINEW-1:0] fill_data,
  output logic             fill_err,
  output logic             err_irq
);
  vstate_e         state_q;
  logic [LW-1:0]   line_q;
  logic            chk_q;
  logic [IDXW-1:0] beat_q;
  logic            err_q;
  logic            irq_q;
  logic            in_win;
  logic [31:0]     crc_now;

  logic req_fire, beat_fire, last_beat, srsp_fire, fill_fire;

  lcv_region_match #(.AW(AW)) u_region (
    .addr (req_addr),
    .lo   (win_lo),
    .hi   (win_hi),
    .hit  (in_win)
  );

  lcv_crc_accum u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (req_fire),
    .en      (beat_fire),
    .word    (mem_rsp_data),
    .crc_out (crc_now)
  );

  lcv_line_buffer #(.LINE_WORDS(LINE_WORDS)) u_buf (
    .clk      (clk),
    .wr_en    (beat_fire),
    .wr_idx   (beat_q),
    .wr_word  (mem_rsp_data),
    .line_out (fill_data)
  );

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    mem_req_valid = (state_q == ST_MREQ);
    mem_rsp_ready = (state_q == ST_DATA);
    sum_req_valid = (state_q == ST_SREQ);
    sum_rsp_ready = (state_q == ST_SRSP);
    fill_valid    = (state_q == ST_OUT);
    mem_req_addr  = {line_q, {OFFW{1'b0}}};
    sum_req_addr  = line_q;
    fill_err      = err_q;
    err_irq       = irq_q;
    req_fire      = req_valid && req_ready;
    beat_fire     = mem_rsp_valid && mem_rsp_ready;
    last_beat     = (beat_q == IDXW'(LINE_WORDS - 1));
    srsp_fire     = sum_rsp_valid && sum_rsp_ready;
    fill_fire     = fill_valid && fill_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      chk_q   <= 1'b0;
      beat_q  <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_fire) begin
          line_q  <= req_addr[AW-1:OFFW];
          chk_q   <= in_win;
          beat_q  <= '0;
          err_q   <= 1'b0;
          state_q <= ST_MREQ;
        end
        ST_MREQ: if (mem_req_ready) state_q <= ST_DATA;
        ST_DATA: if (beat_fire) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= chk_q ? ST_SREQ : ST_OUT;
        end
        ST_SREQ: if (sum_req_ready) state_q <= ST_SRSP;
        ST_SRSP: if (srsp_fire) begin
          err_q   <= (sum_rsp_data != crc_now);
          irq_q   <= (sum_rsp_data != crc_now);
          state_q <= ST_OUT;
        end
        ST_OUT: if (fill_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_data) && $stable(fill_err)));
  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);
  a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);
  a_r5_irq_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (fill_valid && fill_err));
  a_r8_mem_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  a_r2_clean_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !chk_q) |-> !fill_err);
endmodule

// File: tb/tb_line_crc_verifier.sv
`timescale 1ns/1ps
module tb_line_crc_verifier;
  localparam int AW = 12;
  localparam int LW_WORDS = 8;
  localparam int OFFW = 5;
  localparam int LW = AW - OFFW;
  localparam int LINEW = LW_WORDS * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] win_lo = '0, win_hi = '0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic mem_req_valid, mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic sum_req_valid, sum_req_ready = 1'b1;
  logic [LW-1:0] sum_req_addr;
  logic sum_rsp_valid = 1'b0, sum_rsp_ready;
  logic [31:0] sum_rsp_data = '0;
  logic fill_valid, fill_ready = 1'b0;
  logic [LINEW-1:0] fill_data;
  logic fill_err, err_irq;

  line_crc_verifier #(.AW(AW), .LINE_WORDS(LW_WORDS)) dut (.*);

  int checks = 0, fails = 0;
  int mode = 0;
  bit ovr_en = 0;
  logic [31:0] ovr_val = '0;
  int irq_cnt = 0, sum_cnt = 0, mem_cnt = 0;
  logic [AW-1:0] last_mem_addr = '0;
  logic [LW-1:0] last_sum_addr = '0;
  int cyc = 0;

  function automatic logic [31:0] pat(int line, int beat);
    logic [7:0] b0;
    case (mode)
      1: return 32'h0;
      2: return 32'hFFFFFFFF;
      3: begin b0 = 8'(beat * 4); return {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0}; end
      default: return (32'(line) * 32'h9E3779B1) ^ (32'(beat) * 32'h85EBCA6B) ^ 32'h5A5A0F0F;
    endcase
  endfunction

  function automatic logic [31:0] golden(int line);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < LW_WORDS; k++) begin
      logic [31:0] w = pat(line, k);
      for (int b = 0; b < 4; b++) begin
        c = c ^ {24'h0, w[8*b +: 8]};
        for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  function automatic bit corrupt(int line);
    return (line % 7) == 3;
  endfunction

  function automatic logic [31:0] store_val(int line);
    if (ovr_en) return ovr_val;
    return golden(line) ^ (corrupt(line) ? 32'h00000100 : 32'h0);
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: gaps in response words every third cycle
  initial begin
    bit req_pend = 0, rsp_pend = 0, busy = 0;
    int beat = 0, line = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (err_irq) irq_cnt++;
      if (rsp_pend) begin beat++; if (beat == LW_WORDS) busy = 0; end
      if (req_pend) begin busy = 1; beat = 0; line = int'(last_mem_addr >> OFFW); end
      mem_rsp_valid = busy && ((cyc % 3) != 0);
      mem_rsp_data  = busy ? pat(line, beat) : 32'hDEADBEEF;
      req_pend = mem_req_valid && mem_req_ready;
      if (req_pend) begin mem_cnt++; last_mem_addr = mem_req_addr; end
      rsp_pend = mem_rsp_valid && mem_rsp_ready;
    end
  end

  // checksum store model: two-cycle latency
  initial begin
    bit req_pend = 0, rsp_pend = 0;
    int cnt = 0, line = 0;
    forever begin
      @(negedge clk);
      if (rsp_pend) sum_rsp_valid = 1'b0;
      if (req_pend) begin cnt = 2; line = int'(last_sum_addr); end
      else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin sum_rsp_valid = 1'b1; sum_rsp_data = store_val(line); end
      end
      req_pend = sum_req_valid && sum_req_ready;
      if (req_pend) begin sum_cnt++; last_sum_addr = sum_req_addr; end
      rsp_pend = sum_rsp_valid && sum_rsp_ready;
    end
  end

  task automatic do_fill(logic [AW-1:0] a, bit exp_chk, bit exp_err, int hold, string tag);
    int irq0 = irq_cnt, sum0 = sum_cnt, mem0 = mem_cnt, line = int'(a >> OFFW);
    logic [LINEW-1:0] exp_line;
    for (int k = 0; k < LW_WORDS; k++) exp_line[32*k +: 32] = pat(line, k);
    @(negedge clk);
    req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R7", {tag, " ready after accept"}, 64'(req_ready), 0);
    while (!fill_valid) @(negedge clk);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(fill_valid == 1'b1, "R6", {tag, " valid held"}, 64'(fill_valid), 1);
    end
    check(req_ready == 1'b0, "R7", {tag, " busy before fill taken"}, 64'(req_ready), 0);
    check(fill_data == exp_line, "R8", {tag, " line data"}, fill_data[63:0], exp_line[63:0]);
    check(fill_err == exp_err, exp_chk ? "R5" : "R2", {tag, " fill_err"}, 64'(fill_err), 64'(exp_err));
    fill_ready = 1'b1;
    @(negedge clk);
    fill_ready = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R7", {tag, " ready after fill"}, 64'(req_ready), 1);
    check(irq_cnt - irq0 == int'(exp_err), "R5", {tag, " irq pulses"}, 64'(irq_cnt - irq0), 64'(exp_err));
    check(sum_cnt - sum0 == int'(exp_chk), "R1", {tag, " store reads"}, 64'(sum_cnt - sum0), 64'(exp_chk));
    if (exp_chk)
      check(last_sum_addr == LW'(line), "R4", {tag, " store index"}, 64'(last_sum_addr), 64'(line));
    check(mem_cnt - mem0 == 1 && last_mem_addr == a, "R8", {tag, " mem request"},
          64'(last_mem_addr), 64'(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !fill_valid && !mem_req_valid && !sum_req_valid && !err_irq,
          "R9", "reset outputs", {59'h0, req_ready, fill_valid, mem_req_valid, sum_req_valid, err_irq}, 64'h10);

    // R1 sweep over all lines, window [0x200,0x600)
    win_lo = 12'h200; win_hi = 12'h600; mode = 0; ovr_en = 0;
    for (int ln = 0; ln < (1 << LW); ln++) begin
      logic [AW-1:0] a = AW'(ln << OFFW);
      bit in = (a >= 12'h200) && (a < 12'h600);
      do_fill(a, in, in && corrupt(ln), ln % 4, "R1 sweep");
    end

    // R3 known CRC32C vectors on a checked line
    ovr_en = 1;
    mode = 1; ovr_val = 32'h8A9136AA; do_fill(12'h300, 1, 0, 0, "R3 zeros");
    mode = 2; ovr_val = 32'h62A8AB43; do_fill(12'h320, 1, 0, 1, "R3 ones");
    mode = 3; ovr_val = 32'h46DD794E; do_fill(12'h340, 1, 0, 2, "R3 incrementing");
    mode = 3; ovr_val = 32'h46DD794F; do_fill(12'h340, 1, 1, 0, "R5 one-bit mismatch");
    // R2 window empty: lo == hi protects nothing, even a wrong stored value
    win_lo = 12'h300; win_hi = 12'h300; ovr_val = 32'h0;
    do_fill(12'h300, 0, 0, 1, "R2 empty window");
    // R1 single-line window
    win_hi = 12'h320;
    do_fill(12'h300, 1, 1, 0, "R1 single-line window");
    do_fill(12'h320, 0, 0, 0, "R1 end exclusive");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule